// File: doc/BRIEF.md
# Keyed Reset Watchdog Timer

This block is a countdown watchdog that issues a system reset request when software stops servicing it. It runs in one synchronous clock domain. A single-cycle `tick` enable marks each period of the slow 32.768 kHz time base. Software reaches it through a 16-bit register port with byte offsets. The load and control registers are guarded by a write lock. They accept writes only after the unlock key has been written to the lock register, and any other value written there locks them again.

A 32-bit reload value is assembled from two 16-bit halves. Writing the control register with its reload bit set copies that value into the down-counter. While the run bit is set and both gate-enable registers have bit 2 set, every tick lowers the counter by one. When the counter sits at zero with reset-enable set, the block drives `rst_req` high for a fixed number of clocks and then halts until the system reset `rst_n` is applied. A boot-reason register is reset only by the power-on reset `por_n`, so a code written by software before a watchdog-triggered reboot is still readable afterwards.

The controller has four states:
- ST_IDLE: the counter is frozen. It moves to ST_COUNT when run is set and both gates are open.
- ST_COUNT: the counter decrements on each tick. It goes back to ST_IDLE when run or a gate is removed, and moves to ST_FIRE when the counter is zero and reset-enable is set.
- ST_FIRE: `rst_req` is asserted. After the pulse length the state moves to ST_HALT.
- ST_HALT: the block waits for `rst_n`.

Top module: `keyed_wdt`

## Requirements
- R1: After `rst_n`, the block is locked (lock register at 0x20 reads 1 in bit 0). The reload halves and control read 0, and `rst_req` is low.
- R2: Writing 0xE551 to offset 0x20 unlocks the block (bit 0 reads 0). Writing any other value there locks it (bit 0 reads 1).
- R3: While locked, writes to reload-low (0x00), reload-high (0x04) and control (0x08) change nothing that can be read back or observed.
- R4: Control bits are: bit 1 run, bit 2 reload (copies {high,low} into the counter and reads back as 0), bit 3 reset-enable. A control read returns bits 1 and 3 as last written.
- R5: The interface-enable register (0x2C) and the clock-enable register (0x30) accept writes whether locked or not. Counting happens only while bit 2 is set in both.
- R6: The counter drops by exactly one per tick while running, and it holds its value when there is no tick.
- R7: When the counter is zero while run and reset-enable are set, `rst_req` is high for exactly RST_CYCLES consecutive clocks. It then stays low until `rst_n`.
- R8: A counter at zero with reset-enable clear raises no request. Setting reset-enable later fires at once.
- R9: A reload write made before expiry restarts the countdown from the full value.
- R10: The boot-reason register (0x28) is read/write at any time. It keeps its value through `rst_n` and is cleared only by `por_n`.
- R11: Reads of every register are allowed whether the block is locked or not.
- R12: The reload value is {high,low}. A value of 1638 expires after exactly 1638 ticks, which is 50 ms at 32.768 kHz.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset (watchdog logic, lock, enables) |
| por_n | input | 1 | Active-low power-on reset (boot-reason register only) |
| tick | input | 1 | One-cycle enable per 32.768 kHz period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register byte offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| rst_req | output | 1 | Reset request pulse |

## Verification
The properties assume that `addr` and `wdata` are meaningful only when `wr_en` is high, and that `tick` is a single-cycle pulse synchronous to `clk`. They also assume that `por_n` is asserted at least once before `rst_n` is released, so the boot-reason register starts from a known value. The stimulus drives every input on the falling edge and holds it for a full cycle. It raises `tick` at most once every four clocks and applies `por_n` together with `rst_n` at the start. A behavioural model in the bench tracks the lock, registers and countdown, and it is compared with `rst_req` after every rising edge.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 2 * DATA_W;

    localparam logic [ADDR_W-1:0] OFS_LOAD_LO = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_LOAD_HI = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_LOCK    = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_BOOT    = 6'h28;
    localparam logic [ADDR_W-1:0] OFS_IF_EN   = 6'h2C;
    localparam logic [ADDR_W-1:0] OFS_CLK_EN  = 6'h30;

    localparam int CTL_RUN   = 1;
    localparam int CTL_NEW   = 2;
    localparam int CTL_RSTEN = 3;
    localparam int EN_BIT    = 2;
    localparam int NUM_GATES = 2;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 16'hE551;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_FIRE,
        ST_HALT
    } wdt_state_e;
endpackage

// File: rtl/keyed_wdt_regs.sv
module keyed_wdt_regs
    import keyed_wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  load_val,
    output logic              load_pulse,
    output logic              run,
    output logic              rst_en,
    output logic              gate_ok,
    output logic              locked,
    output logic [DATA_W-1:0] boot_code
);
    logic [DATA_W-1:0] lo_q, hi_q, boot_q;
    logic              run_q, rsten_q, locked_q;
    logic [DATA_W-1:0] en_q [NUM_GATES];
    logic [NUM_GATES-1:0] gate_bits;

    logic open_wr;
    assign open_wr = wr_en && !locked_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q <= 1'b1;
            lo_q     <= '0;
            hi_q     <= '0;
            run_q    <= 1'b0;
            rsten_q  <= 1'b0;
        end else begin
            if (wr_en && addr == OFS_LOCK)
                locked_q <= (wdata != UNLOCK_KEY);
            if (open_wr && addr == OFS_LOAD_LO)
                lo_q <= wdata;
            if (open_wr && addr == OFS_LOAD_HI)
                hi_q <= wdata;
            if (open_wr && addr == OFS_CTRL) begin
                run_q   <= wdata[CTL_RUN];
                rsten_q <= wdata[CTL_RSTEN];
            end
        end
    end

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        localparam logic [ADDR_W-1:0] GATE_OFS = (g == 0) ? OFS_IF_EN : OFS_CLK_EN;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                en_q[g] <= '0;
            else if (wr_en && addr == GATE_OFS)
                en_q[g] <= wdata;
        end
        assign gate_bits[g] = en_q[g][EN_BIT];
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            boot_q <= '0;
        else if (wr_en && addr == OFS_BOOT)
            boot_q <= wdata;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_LOAD_LO: rdata = lo_q;
            OFS_LOAD_HI: rdata = hi_q;
            OFS_CTRL: begin
                rdata[CTL_RUN]   = run_q;
                rdata[CTL_RSTEN] = rsten_q;
            end
            OFS_LOCK:   rdata[0] = locked_q;
            OFS_BOOT:   rdata = boot_q;
            OFS_IF_EN:  rdata = en_q[0];
            OFS_CLK_EN: rdata = en_q[1];
            default:    rdata = '0;
        endcase
    end

    assign load_val   = {hi_q, lo_q};
    assign load_pulse = open_wr && addr == OFS_CTRL && wdata[CTL_NEW];
    assign run        = run_q;
    assign rst_en     = rsten_q;
    assign gate_ok    = &gate_bits;
    assign locked     = locked_q;
    assign boot_code  = boot_q;
endmodule

// File: rtl/keyed_wdt_core.sv
module keyed_wdt_core
    import keyed_wdt_pkg::*;
#(
    parameter int CW         = 32,
    parameter int RST_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          gate_ok,
    input  logic          rst_en,
    input  logic          load_pulse,
    input  logic [CW-1:0] load_val,
    output logic          rst_req,
    output logic [CW-1:0] count
);
    localparam int FC_W = $clog2(RST_CYCLES + 1);
    localparam logic [FC_W-1:0] FC_LAST = FC_W'(RST_CYCLES - 1);

    wdt_state_e      state_q, state_d;
    logic [FC_W-1:0] fc_q;
    logic [CW-1:0]   cnt_q;
    logic            active;

    assign active = run && gate_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (active) state_d = ST_COUNT;
            ST_COUNT: begin
                if (!active)
                    state_d = ST_IDLE;
                else if (cnt_q == '0 && rst_en)
                    state_d = ST_FIRE;
            end
            ST_FIRE:  if (fc_q == FC_LAST) state_d = ST_HALT;
            ST_HALT:  state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fc_q    <= '0;
        end else begin
            state_q <= state_d;
            fc_q    <= (state_q == ST_FIRE) ? fc_q + 1'b1 : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_pulse)
            cnt_q <= load_val;
        else if (state_q == ST_COUNT && active && tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    always_comb begin
        rst_req = (state_q == ST_FIRE);
        count   = cnt_q;
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req
);
    logic [CNT_W-1:0]  load_val_w, cnt_w;
    logic              load_pulse_w, run_w, rst_en_w, gate_ok_w, locked_w;
    logic [DATA_W-1:0] boot_w;

    keyed_wdt_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_n      (por_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .load_val   (load_val_w),
        .load_pulse (load_pulse_w),
        .run        (run_w),
        .rst_en     (rst_en_w),
        .gate_ok    (gate_ok_w),
        .locked     (locked_w),
        .boot_code  (boot_w)
    );

    keyed_wdt_core #(
        .CW         (CNT_W),
        .RST_CYCLES (RST_CYCLES)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .run        (run_w),
        .gate_ok    (gate_ok_w),
        .rst_en     (rst_en_w),
        .load_pulse (load_pulse_w),
        .load_val   (load_val_w),
        .rst_req    (rst_req),
        .count      (cnt_w)
    );
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
    import keyed_wdt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              por_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              locked,
    input logic [CNT_W-1:0]  load_val,
    input logic              load_pulse,
    input logic              rst_en,
    input logic              rst_req,
    input logic [CNT_W-1:0]  count,
    input logic [DATA_W-1:0] boot_code
);
    AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_LOCK && wdata == UNLOCK_KEY) |=> !locked); // R2

    AST_OTHER_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_LOCK && wdata != UNLOCK_KEY) |=> locked); // R2

    AST_LOCKED_LOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(load_val)); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> ($past(load_pulse) || count == $past(count) - 1'b1)); // R6

    AST_FIRE_NEEDS_RSTEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(rst_en)); // R7

    AST_BOOT_HELD: assert property (@(posedge clk) disable iff (!por_n)
        !(wr_en && addr == OFS_BOOT) |=> $stable(boot_code)); // R10
endmodule

bind keyed_wdt keyed_wdt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .por_n      (por_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .locked     (locked_w),
    .load_val   (load_val_w),
    .load_pulse (load_pulse_w),
    .rst_en     (rst_en_w),
    .rst_req    (rst_req),
    .count      (cnt_w),
    .boot_code  (boot_w)
);

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
    localparam int RST_CYCLES = 8;

    logic        clk = 0, rst_n = 0, por_n = 0, tick = 0, wr_en = 0;
    logic [5:0]  addr = 0;
    logic [15:0] wdata = 0;
    logic [15:0] rdata;
    logic        rst_req;

    keyed_wdt #(.RST_CYCLES(RST_CYCLES)) u_dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick(tick),
        .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rst_req(rst_req)
    );

    always #4 clk = ~clk;

    int tests = 0, fails = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit     m_locked = 1, m_run = 0, m_rsten = 0;
    int     m_lo = 0, m_hi = 0, m_en0 = 0, m_en1 = 0, m_boot = 0;
    longint m_cnt = 0;
    int     m_st = 0, m_fc = 0;   // 0 idle, 1 counting, 2 firing, 3 halted

    always @(posedge clk) begin
        automatic bit o_lock = m_locked;
        automatic bit act = m_run && m_en0[2] && m_en1[2];
        automatic int nxt = m_st;
        if (!por_n) m_boot = 0;
        else if (wr_en && addr == 6'h28) m_boot = wdata;
        if (!rst_n) begin
            m_locked = 1; m_run = 0; m_rsten = 0; m_lo = 0; m_hi = 0;
            m_en0 = 0; m_en1 = 0; m_cnt = 0; m_st = 0; m_fc = 0;
        end else begin
            if (m_st == 0 && act) nxt = 1;
            else if (m_st == 1 && !act) nxt = 0;
            else if (m_st == 1 && m_cnt == 0 && m_rsten) nxt = 2;
            else if (m_st == 2 && m_fc == RST_CYCLES - 1) nxt = 3;
            m_fc = (m_st == 2) ? m_fc + 1 : 0;
            if (!o_lock && wr_en && addr == 6'h08 && wdata[2]) m_cnt = m_hi * 65536 + m_lo;
            else if (m_st == 1 && act && tick && m_cnt != 0) m_cnt = m_cnt - 1;
            if (wr_en && addr == 6'h20) m_locked = (wdata != 16'hE551);
            if (!o_lock && wr_en && addr == 6'h00) m_lo = wdata;
            if (!o_lock && wr_en && addr == 6'h04) m_hi = wdata;
            if (!o_lock && wr_en && addr == 6'h08) begin m_run = wdata[1]; m_rsten = wdata[3]; end
            if (wr_en && addr == 6'h2C) m_en0 = wdata;
            if (wr_en && addr == 6'h30) m_en1 = wdata;
            m_st = nxt;
        end
    end

    // per-cycle comparison and observation counters
    int pulse_cycles = 0, ticks_seen = 0;
    bit seen_fire = 0;
    always @(posedge clk) begin
        if (tick && !seen_fire) ticks_seen++;
        #2;
        if (por_n && rst_n)
            check(rst_req === (m_st == 2), "R7 model compare rst_req", rst_req, m_st == 2);
        if (rst_req) begin pulse_cycles++; seen_fire = 1; end
    end

    bit tick_on = 0;
    int tphase = 0;
    always @(negedge clk) begin
        if (tick_on) begin
            tphase = (tphase + 1) % 4;
            tick = (tphase == 0);
        end else tick = 0;
    end

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk); addr = a; #1;
        check(rdata == exp, tag, rdata, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sys_reset();
        @(negedge clk); rst_n = 0; tick_on = 0;
        wait_cyc(3); rst_n = 1;
        wait_cyc(1);
        pulse_cycles = 0;
    endtask

    task automatic open_up();
        wr(6'h20, 16'hE551);
        wr(6'h2C, 16'h0004);
        wr(6'h30, 16'h0004);
    endtask

    initial begin
        wait_cyc(3); por_n = 1; rst_n = 1; wait_cyc(2);

        // R1 reset state
        rd(6'h20, 16'h0001, "R1 locked after reset");
        rd(6'h00, 16'h0000, "R1 load low after reset");
        rd(6'h08, 16'h0000, "R1 control after reset");
        check(rst_req == 0, "R1 rst_req low after reset", rst_req, 0);

        // R3 locked writes ignored, R5 gates writable while locked
        wr(6'h00, 16'h1234); wr(6'h08, 16'h000E);
        rd(6'h00, 16'h0000, "R3 locked load low write ignored");
        rd(6'h08, 16'h0000, "R3 locked control write ignored");
        wr(6'h2C, 16'h0004);
        rd(6'h2C, 16'h0004, "R5 gate register writable while locked");

        // R2 unlock and relock
        wr(6'h20, 16'hE551);
        rd(6'h20, 16'h0000, "R2 key unlocks");
        wr(6'h00, 16'h1234);
        rd(6'h00, 16'h1234, "R2 unlocked write accepted");
        wr(6'h20, 16'h1AAE);
        rd(6'h20, 16'h0001, "R2 other value relocks");
        wr(6'h00, 16'h5555);
        rd(6'h00, 16'h1234, "R11 read while locked returns held value");
        sys_reset();

        // R5 gating, R7 pulse length, R4 control readback
        wr(6'h20, 16'hE551);
        wr(6'h00, 16'd20); wr(6'h08, 16'h000E);
        rd(6'h08, 16'h000A, "R4 control reads run and reset-enable, reload reads 0");
        tick_on = 1; wait_cyc(200);
        check(pulse_cycles == 0, "R5 no gates open, no reset", pulse_cycles, 0);
        wr(6'h2C, 16'h0004); wait_cyc(200);
        check(pulse_cycles == 0, "R5 one gate open, no reset", pulse_cycles, 0);
        wr(6'h30, 16'h0004); wait_cyc(150);
        check(pulse_cycles == RST_CYCLES, "R7 pulse length", pulse_cycles, RST_CYCLES);
        wait_cyc(60);
        check(pulse_cycles == RST_CYCLES && rst_req == 0, "R7 stays low after pulse", pulse_cycles, RST_CYCLES);

        // R10 boot reason survives system reset
        wr(6'h28, 16'h00F0);
        rd(6'h28, 16'h00F0, "R10 boot reason write");
        wr(6'h28, (16'h00F0 & ~16'h00F0) | 16'h0040);
        sys_reset();
        rd(6'h28, 16'h0040, "R10 boot reason kept through rst_n");
        rd(6'h20, 16'h0001, "R1 relocked by rst_n");
        rd(6'h08, 16'h0000, "R1 control cleared by rst_n");
        @(negedge clk); por_n = 0; wait_cyc(2); por_n = 1; wait_cyc(1);
        rd(6'h28, 16'h0000, "R10 boot reason cleared by por_n");

        // R6 no tick, no count
        open_up();
        wr(6'h00, 16'd30); wr(6'h08, 16'h000E);
        wait_cyc(300);
        check(pulse_cycles == 0, "R6 counter holds without ticks", pulse_cycles, 0);
        tick_on = 1; wait_cyc(170);
        check(pulse_cycles == RST_CYCLES, "R6 ticks bring expiry", pulse_cycles, RST_CYCLES);
        sys_reset();

        // R8 expiry without reset-enable
        open_up();
        wr(6'h00, 16'd10); wr(6'h08, 16'h0006);
        tick_on = 1; wait_cyc(200);
        check(pulse_cycles == 0, "R8 zero without reset-enable is silent", pulse_cycles, 0);
        wr(6'h08, 16'h000A); wait_cyc(20);
        check(pulse_cycles == RST_CYCLES, "R8 enabling at zero fires at once", pulse_cycles, RST_CYCLES);
        sys_reset();

        // R9 servicing restarts the countdown
        open_up();
        wr(6'h00, 16'd40); wr(6'h08, 16'h000E);
        tick_on = 1;
        for (int i = 0; i < 10; i++) begin
            wait_cyc(100); wr(6'h08, 16'h000E);
        end
        check(pulse_cycles == 0, "R9 serviced watchdog never fires", pulse_cycles, 0);
        wait_cyc(250);
        check(pulse_cycles == RST_CYCLES, "R9 fires once service stops", pulse_cycles, RST_CYCLES);
        sys_reset();

        // R12 50 ms reload
        open_up();
        wr(6'h04, 16'h0000); wr(6'h00, 16'd1638);
        rd(6'h00, 16'h0666, "R12 load low holds 1638");
        wr(6'h08, 16'h000E);
        wait_cyc(3);
        ticks_seen = 0; seen_fire = 0; tick_on = 1;
        for (int i = 0; i < 8000 && !seen_fire; i++) wait_cyc(1);
        check(ticks_seen == 1638, "R12 expiry after 1638 ticks", ticks_seen, 1638);
        sys_reset();

        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule